// File: doc/BRIEF.md
# Extended Multiblock Phase Counter

This block keeps the local extended-multiblock phase of a 64b/66b serial converter link. Each link clock stands for one 66-bit block. The count steps once per clock through E multiblocks of 32 blocks each, so it covers the values 0 to E*32-1 and then returns to 0. Two pulse outputs mark the last block of every 32-block multiblock and the last block of the whole extended multiblock. Link framing logic downstream uses these pulses to place its multiblock boundaries.

The block has two modes. In free-running mode the phase is set by the release of link reset alone, and the SYSREF input is ignored. In synced mode the counter waits at 0 after reset until the first SYSREF rising edge. That edge restarts the counter with a fixed latency, so every device fed the same SYSREF ends up at the same phase. After that first capture, each later SYSREF edge is checked against the running phase. An edge that does not fall on a wrap boundary sets a sticky error flag. The counter is realigned to such an edge only while the re-arm input is high.

Top module: `xmb_phase_counter`

## Requirements
- R1: `count_o` never exceeds E*32-1. From the value E*32-1 it always goes to 0 at the next clock.
- R2: With `det_mode_i` = 0 (free-running), `count_o` is 0 while `rst_i` is high. From the first clock edge after reset release it goes up by one per clock, modulo E*32. SYSREF has no effect on the count, `sysref_seen_o` or `align_err_o`.
- R3: With `det_mode_i` = 1 (synced), `count_o` stays at 0 after reset until the first SYSREF rising edge is detected. `sysref_seen_o` goes high when that first edge is taken and stays high until reset.
- R4: In synced mode, suppose `sysref_i` is first sampled high at clock edge k. Then `count_o` still shows its undisturbed value after edge k, and shows 0 after edge k+1 whenever a restart is taken. This gives a latency of two link clocks with the default two synchronizer stages.
- R5: After capture, a SYSREF edge is aligned when its restart coincides with the counter's own wrap. This means the count read after edge k is E*32-1. Aligned edges never set `align_err_o`, at any whole multiple of the wrap period.
- R6: After capture, a misaligned SYSREF edge sets `align_err_o`. The flag stays high until reset. With `rearm_i` low, the count continues undisturbed.
- R7: A misaligned SYSREF edge taken while `rearm_i` is high (held from edge k through edge k+1) restarts the count at 0 after edge k+1, with the same latency as in R4.
- R8: `emb_wrap_o` is high exactly while `count_o` equals E*32-1. `mb_wrap_o` is high exactly while the low five bits of `count_o` are all ones (block 31 of a multiblock).
- R9: `rst_i` high clears `count_o`, `sysref_seen_o` and `align_err_o` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock, one 66-bit block per cycle |
| rst_i | input | 1 | Synchronous link reset, active high |
| sysref_i | input | 1 | Shared SYSREF, asynchronous to the link clock |
| det_mode_i | input | 1 | 0 selects free-running mode, 1 selects synced mode |
| rearm_i | input | 1 | Allows realignment on a misaligned SYSREF edge |
| count_o | output | clog2(E*32) | Current block index within the extended multiblock |
| emb_wrap_o | output | 1 | High on the last block of the extended multiblock |
| mb_wrap_o | output | 1 | High on the last block of each 32-block multiblock |
| sysref_seen_o | output | 1 | First SYSREF edge has been captured (synced mode) |
| align_err_o | output | 1 | Sticky flag for a SYSREF edge off a wrap boundary |

## Verification
The synced counter is driven by a table of SYSREF edges.

- The first edge arrives while the counter is held, which separates the hold state from a running count.
- Edges one wrap period apart and two wrap periods apart show that slower periodic SYSREF is accepted without error.
- An off-boundary edge with re-arm low shows that the flag is set while the count is left undisturbed.
- An off-boundary edge with re-arm high shows that the restart happens, and the count read one clock before it separates a latency of two from one or three.

A second instance with E=3 exercises the compare-based wrap variant. In free-running mode it receives the same SYSREF pulses, which shows they are ignored. After a reset the modes are swapped, so that each E value is tried in both modes.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

   localparam int BLK_PER_MB = 32;
   localparam int MB_IDX_W   = 5;
   localparam int MAX_MB     = 32;

   typedef enum logic {
      LINK_FREE   = 1'b0,
      LINK_SYNCED = 1'b1
   } link_mode_e;

   function automatic int emb_width(input int mbs);
      return $clog2(mbs * BLK_PER_MB);
   endfunction

endpackage

// File: rtl/xmb_sysref_sync.sv
module xmb_sysref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic sysref_i,
   output logic rise_o
);

   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sr_q <= '0;
      end else begin
         sr_q <= {sr_q[STAGES-2:0], sysref_i};
      end
   end

   // Edge taken between the last two stages: latency equals STAGES edges.
   assign rise_o = sr_q[STAGES-2] & ~sr_q[STAGES-1];

   // R4
   rise_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |=> !rise_o);

endmodule

// File: rtl/xmb_count_core.sv
module xmb_count_core import xmb_pkg::*; #(
   parameter int MB_PER_EMB = 1,
   localparam int TOTAL = MB_PER_EMB * BLK_PER_MB,
   localparam int CW    = emb_width(MB_PER_EMB)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic          run_i,
   output logic [CW-1:0] count_o,
   output logic          last_emb_o,
   output logic          last_mb_o
);

   localparam logic [CW-1:0] TOP_V = CW'(TOTAL - 1);

   logic [CW-1:0] count_q;
   logic [CW-1:0] count_nxt;

   generate
      if ((TOTAL & (TOTAL - 1)) == 0) begin : g_pow2_wrap
         always_comb count_nxt = count_q + CW'(1);
      end else begin : g_cmp_wrap
         always_comb count_nxt = (count_q == TOP_V) ? '0 : count_q + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= '0;
      end else if (run_i) begin
         count_q <= count_nxt;
      end
   end

   assign count_o    = count_q;
   assign last_emb_o = (count_q == TOP_V);
   assign last_mb_o  = &count_q[MB_IDX_W-1:0];

   // R1
   count_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      count_q <= TOP_V);

   // R1
   top_to_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (count_q == TOP_V) && (run_i || load_i) |=> count_q == '0);

   // R2
   step_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_i && !load_i && count_q != TOP_V) |=> count_q == $past(count_q) + CW'(1));

   // R3
   hold_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!run_i && !load_i) |=> $stable(count_q));

endmodule

// File: rtl/xmb_align_monitor.sv
module xmb_align_monitor import xmb_pkg::*; #(
   parameter int MB_PER_EMB = 1,
   localparam int TOTAL = MB_PER_EMB * BLK_PER_MB,
   localparam int CW    = emb_width(MB_PER_EMB)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  link_mode_e    mode_i,
   input  logic          rise_i,
   input  logic          rearm_i,
   input  logic [CW-1:0] count_i,
   output logic          load_o,
   output logic          run_o,
   output logic          seen_o,
   output logic          err_o
);

   localparam logic [CW-1:0] TOP_V = CW'(TOTAL - 1);

   logic seen_q;
   logic err_q;
   logic synced;
   logic on_boundary;

   assign synced      = (mode_i == LINK_SYNCED);
   assign on_boundary = (count_i == TOP_V);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         seen_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (synced && rise_i) begin
         if (!seen_q) begin
            seen_q <= 1'b1;
         end else if (!on_boundary) begin
            err_q <= 1'b1;
         end
      end
   end

   assign load_o = synced && rise_i && (!seen_q || rearm_i);
   assign run_o  = !synced || seen_q;
   assign seen_o = seen_q;
   assign err_o  = err_q;

   // R3
   seen_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      seen_q |=> seen_q);

   // R6
   err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      err_q |=> err_q);

   // R5
   err_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(err_q) |-> $past(rise_i) && $past(count_i) != TOP_V);

endmodule

// File: rtl/xmb_phase_counter.sv
module xmb_phase_counter import xmb_pkg::*; #(
   parameter int MB_PER_EMB  = 1,
   parameter int SYNC_STAGES = 2,
   localparam int CW = emb_width(MB_PER_EMB)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          sysref_i,
   input  logic          det_mode_i,
   input  logic          rearm_i,
   output logic [CW-1:0] count_o,
   output logic          emb_wrap_o,
   output logic          mb_wrap_o,
   output logic          sysref_seen_o,
   output logic          align_err_o
);

   generate
      if (MB_PER_EMB < 1 || MB_PER_EMB > MAX_MB) begin : g_bad_mb
         $error("MB_PER_EMB must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   link_mode_e    mode;
   logic          sr_rise;
   logic          load;
   logic          run;
   logic [CW-1:0] count;

   assign mode = link_mode_e'(det_mode_i);

   xmb_sysref_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .sysref_i (sysref_i),
      .rise_o   (sr_rise)
   );

   xmb_align_monitor #(
      .MB_PER_EMB (MB_PER_EMB)
   ) u_mon (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .mode_i  (mode),
      .rise_i  (sr_rise),
      .rearm_i (rearm_i),
      .count_i (count),
      .load_o  (load),
      .run_o   (run),
      .seen_o  (sysref_seen_o),
      .err_o   (align_err_o)
   );

   xmb_count_core #(
      .MB_PER_EMB (MB_PER_EMB)
   ) u_core (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (load),
      .run_i      (run),
      .count_o    (count),
      .last_emb_o (emb_wrap_o),
      .last_mb_o  (mb_wrap_o)
   );

   assign count_o = count;

   // R4
   realign_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (det_mode_i && sr_rise && (!sysref_seen_o || rearm_i)) |=> count_o == '0);

   // R8
   emb_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      emb_wrap_o |=> count_o == '0);

   // R2
   free_no_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !det_mode_i |-> !align_err_o && !sysref_seen_o);

   // R9
   reset_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> count_o == '0 && !align_err_o && !sysref_seen_o);

endmodule

// File: tb/xmb_phase_counter_bench.sv
`timescale 1ns/1ps
module xmb_phase_counter_bench;

   typedef struct packed {
      logic [7:0] gap;
      logic       rearm;
      logic [7:0] mid;
      logic [7:0] fin;
      logic       err;
   } row_t;

   // E=1 synced instance, sample point after each row shows 'fin'
   localparam row_t TBL [7] = '{
      '{8'd5,  1'b0, 8'd0,  8'd0,  1'b0},
      '{8'd30, 1'b0, 8'd31, 8'd0,  1'b0},
      '{8'd62, 1'b0, 8'd31, 8'd0,  1'b0},
      '{8'd30, 1'b1, 8'd31, 8'd0,  1'b0},
      '{8'd10, 1'b0, 8'd11, 8'd12, 1'b1},
      '{8'd5,  1'b1, 8'd18, 8'd0,  1'b1},
      '{8'd30, 1'b0, 8'd31, 8'd0,  1'b1}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sr_a = 1'b0, det_a = 1'b1, rearm_a = 1'b0;
   logic sr_b = 1'b0, det_b = 1'b0, rearm_b = 1'b0;
   logic [4:0] cnt_a;
   logic [6:0] cnt_b;
   logic emb_a, mb_a, seen_a, err_a;
   logic emb_b, mb_b, seen_b, err_b;

   int checks = 0;
   int fails  = 0;
   int ticks  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   xmb_phase_counter #(.MB_PER_EMB(1)) u_xmb_phase_counter (
      .clk_i(clk), .rst_i(rst), .sysref_i(sr_a), .det_mode_i(det_a), .rearm_i(rearm_a),
      .count_o(cnt_a), .emb_wrap_o(emb_a), .mb_wrap_o(mb_a),
      .sysref_seen_o(seen_a), .align_err_o(err_a));

   xmb_phase_counter #(.MB_PER_EMB(3)) u_xmb_phase_counter_e3 (
      .clk_i(clk), .rst_i(rst), .sysref_i(sr_b), .det_mode_i(det_b), .rearm_i(rearm_b),
      .count_o(cnt_b), .emb_wrap_o(emb_b), .mb_wrap_o(mb_b),
      .sysref_seen_o(seen_b), .align_err_o(err_b));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      ticks++;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int t0;
      @(negedge clk);
      repeat (3) tick();
      check("R9 reset count A", cnt_a, 0);
      check("R9 reset seen A", seen_a, 0);
      check("R9 reset err A", err_a, 0);
      check("R9 reset count B", cnt_b, 0);

      rst = 1'b0;
      t0 = ticks;

      for (int i = 0; i < 7; i++) begin
         repeat (int'(TBL[i].gap)) tick();
         if (i == 0) check("R3 held at zero before SYSREF", cnt_a, 0);
         sr_a = 1'b1; rearm_a = TBL[i].rearm; sr_b = 1'b1;
         tick();
         check("R4 count one edge after SYSREF", cnt_a, int'(TBL[i].mid));
         check("R8 emb wrap at last block", emb_a, (TBL[i].mid == 8'd31) ? 1 : 0);
         tick();
         check("R5 R6 R7 count two edges after SYSREF", cnt_a, int'(TBL[i].fin));
         check("R5 R6 error flag", err_a, int'(TBL[i].err));
         check("R2 free count ignores SYSREF", cnt_b, (ticks - t0) % 96);
         check("R2 free err stays low", err_b, 0);
         check("R2 free seen stays low", seen_b, 0);
         if (i == 0) check("R3 seen after capture", seen_a, 1);
         sr_a = 1'b0; rearm_a = 1'b0; sr_b = 1'b0;
      end

      // R1 / R8 on E=1: count 0 now
      repeat (31) tick();
      check("R1 E1 reaches top", cnt_a, 31);
      check("R8 E1 mb wrap", mb_a, 1);
      tick();
      check("R1 E1 wraps to zero", cnt_a, 0);
      check("R8 E1 emb low after wrap", emb_a, 0);

      // R1 / R8 on E=3 free running
      while ((ticks - t0) % 96 != 31) tick();
      check("R8 E3 mb wrap at 31", mb_b, 1);
      check("R8 E3 emb low at 31", emb_b, 0);
      while ((ticks - t0) % 96 != 95) tick();
      check("R1 E3 top value", cnt_b, 95);
      check("R8 E3 emb wrap at top", emb_b, 1);
      check("R8 E3 mb wrap at top", mb_b, 1);
      tick();
      check("R1 E3 wraps to zero", cnt_b, 0);

      // R9 reset mid-run, then swap modes
      rst = 1'b1;
      tick();
      check("R9 count cleared", cnt_a, 0);
      check("R9 err cleared", err_a, 0);
      check("R9 seen cleared", seen_a, 0);
      det_a = 1'b0; det_b = 1'b1;
      tick();
      rst = 1'b0;
      t0 = ticks;

      repeat (10) tick();
      check("R3 E3 held at zero", cnt_b, 0);
      check("R2 E1 free count", cnt_a, (ticks - t0) % 32);
      sr_b = 1'b1; sr_a = 1'b1;
      tick();
      tick();
      check("R3 E3 seen after capture", seen_b, 1);
      check("R4 E3 zero after capture", cnt_b, 0);
      sr_b = 1'b0; sr_a = 1'b0;
      repeat (10) tick();
      check("R3 E3 runs after capture", cnt_b, 10);
      sr_b = 1'b1; rearm_b = 1'b1;
      tick();
      check("R4 E3 undisturbed one edge after", cnt_b, 11);
      tick();
      check("R7 E3 realigned", cnt_b, 0);
      check("R6 E3 err set", err_b, 1);
      check("R2 E1 free count after SYSREF", cnt_a, (ticks - t0) % 32);
      check("R2 E1 err low", err_a, 0);
      sr_b = 1'b0; rearm_b = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule